// File: doc/BRIEF.md
# Soft Interrupt Pending Register

This block keeps a 17-bit register of pending software-raised interrupts, together with a 4-bit processor interrupt level. It turns the two into one request line per pending bit. Bits 15 down to 1 each stand for the interrupt level equal to their index. A bit in that range requests service only when its level is strictly above the current processor level. Bit 0 is the tick-match flag and bit 16 is the system-tick-match flag. Both request service whenever they are set and the processor level is below 14.

Software reaches the block through a simple address/strobe bus with 32-bit data. Address 0 is a direct write of the pending register. Address 1 is a set alias that ORs the written value in. Address 2 is a clear alias that removes every bit written as 1. Address 3 holds the processor interrupt level. Two single-cycle pulses from the timer-compare logic set the tick and system-tick bits directly. The request lines are computed combinationally from the stored state, so they change in the same cycle as the register or level they depend on.

Top module: `softint_pend`

## Requirements
- R1: After reset the pending register reads 0, the interrupt level reads 15, and every request output is low.
- R2: A write to address 0 loads data bits 16..0 into the pending register. Data bits 31..17 are ignored, and reads of addresses 0, 1 and 2 return the register with bits 31..17 as zero.
- R3: A write to address 1 ORs data bits 16..0 into the pending register and leaves every other bit unchanged.
- R4: A write to address 2 clears every pending bit whose data bit is 1 and keeps every other bit.
- R5: A write to address 3 loads data bits 3..0 into the interrupt level, which reads back at address 3 as zero-extended. With no write to address 3, the level holds its value.
- R6: For each index k from 1 to 15, request output k is high exactly when pending bit k is set and k is greater than the interrupt level. No request is high for a pending bit that is clear.
- R7: Request outputs 0 and 16 are high exactly when their pending bit is set and the interrupt level is below 14.
- R8: A pulse on tickMatch sets pending bit 0, and a pulse on stickMatch sets pending bit 16, at the next clock edge.
- R9: When a hardware set pulse and a software write to address 0 or 2 fall in the same cycle, the hardware-set bit ends up at 1.
- R10: Request outputs reflect a write or a level change in the first cycle after the clock edge that stores it. No extra register stage lies in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 2 | Register address: 0 direct, 1 set alias, 2 clear alias, 3 level |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, zero-extended |
| tickMatch | input | 1 | Single-cycle pulse that sets pending bit 0 |
| stickMatch | input | 1 | Single-cycle pulse that sets pending bit 16 |
| intReq | output | 17 | Per-bit interrupt request lines |

## Verification
The request logic is tried with the interrupt level at 0, 7, 13, 14 and 15 while the pending register holds a mix of ones. Level 0 shows every set bit requesting. Level 7 separates the per-level comparison from the fixed timer threshold. Levels 13 against 14 locate the timer-bit cutoff exactly, and also the strict greater-than on bits 14 and 15. Level 15 masks everything. Writes through the set and clear aliases use patterns that overlap already-set bits, and a write with only upper data bits set shows that those bits are discarded. Hardware pulses are sent alone, with a direct write and with a clear-alias write, to show that the pulse wins.

// File: rtl/softint_pkg.sv
package softint_pkg;

  localparam int PEND_W       = 17;
  localparam int PIL_W        = 4;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 2;
  localparam int TIMER_THRESH = 14;
  localparam int PIL_RESET    = 15;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DIRECT = 2'd0,
    ADDR_SET    = 2'd1,
    ADDR_CLR    = 2'd2,
    ADDR_LEVEL  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic loadPend;
    logic setPend;
    logic clrPend;
    logic loadPil;
  } pendStrobe_t;

endpackage

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busWrEn,
  input  logic [AW-1:0] busAddr,
  output pendStrobe_t   strobes
);

  always_comb begin
    strobes = '0;
    if (busWrEn) begin
      unique case (regAddr_e'(busAddr))
        ADDR_DIRECT: strobes.loadPend = 1'b1;
        ADDR_SET:    strobes.setPend  = 1'b1;
        ADDR_CLR:    strobes.clrPend  = 1'b1;
        ADDR_LEVEL:  strobes.loadPil  = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/softint_datapath.sv
module softint_datapath
  import softint_pkg::*;
#(
  parameter int PW       = PEND_W,
  parameter int LW       = PIL_W,
  parameter int LVL_INIT = PIL_RESET
) (
  input  logic          clk,
  input  logic          rstN,
  input  pendStrobe_t   strobes,
  input  logic [PW-1:0] wrBits,
  input  logic          tickMatch,
  input  logic          stickMatch,
  output logic [PW-1:0] pendReg,
  output logic [LW-1:0] pilReg
);

  localparam int TOP_BIT = PW - 1;

  logic [PW-1:0] hwMask;
  logic [PW-1:0] pendNext;

  always_comb begin
    hwMask          = '0;
    hwMask[0]       = tickMatch;
    hwMask[TOP_BIT] = stickMatch;
  end

  always_comb begin
    pendNext = pendReg;
    if (strobes.loadPend) pendNext = wrBits;
    if (strobes.setPend)  pendNext = pendNext | wrBits;
    if (strobes.clrPend)  pendNext = pendNext & ~wrBits;
    pendNext = pendNext | hwMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      pilReg  <= LW'(LVL_INIT);
    end else begin
      pendReg <= pendNext;
      if (strobes.loadPil) pilReg <= wrBits[LW-1:0];
    end
  end

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.setPend) && !$past(strobes.loadPend) && !$past(strobes.clrPend)
      |-> ((pendReg & $past(wrBits)) == $past(wrBits)));

  // R4
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clrPend) && !$past(tickMatch) && !$past(stickMatch)
      |-> ((pendReg & $past(wrBits)) == '0));

  // R8
  tick_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(tickMatch) |-> pendReg[0]);

  // R9
  stick_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stickMatch) |-> pendReg[TOP_BIT]);

  // R5
  pil_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadPil) |-> $stable(pilReg));

endmodule

// File: rtl/softint_reqgen.sv
module softint_reqgen
  import softint_pkg::*;
#(
  parameter int PW     = PEND_W,
  parameter int LW     = PIL_W,
  parameter int THRESH = TIMER_THRESH
) (
  input  logic [PW-1:0] pendReg,
  input  logic [LW-1:0] pilReg,
  output logic [PW-1:0] intReq
);

  localparam int TOP_BIT = PW - 1;

  logic timerOpen;
  assign timerOpen = (pilReg < LW'(THRESH));

  for (genvar g = 0; g < PW; g++) begin : g_req
    if (g == 0 || g == TOP_BIT) begin : g_timer
      assign intReq[g] = pendReg[g] & timerOpen;
    end else begin : g_level
      localparam logic [LW:0] LEVEL = (LW+1)'(g);
      assign intReq[g] = pendReg[g] & (LEVEL > {1'b0, pilReg});
    end
  end

endmodule

// File: rtl/softint_pend.sv
module softint_pend
  import softint_pkg::*;
#(
  parameter int PW       = PEND_W,
  parameter int LW       = PIL_W,
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int THRESH   = TIMER_THRESH,
  parameter int LVL_INIT = PIL_RESET
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWrData,
  output logic [DW-1:0] busRdData,
  input  logic          tickMatch,
  input  logic          stickMatch,
  output logic [PW-1:0] intReq
);

  pendStrobe_t   strobes;
  logic [PW-1:0] pendReg;
  logic [LW-1:0] pilReg;
  logic          unusedUpper;

  assign unusedUpper = ^busWrData[DW-1:PW];

  softint_ctrl #(.AW(AW)) ctrl_i (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  softint_datapath #(.PW(PW), .LW(LW), .LVL_INIT(LVL_INIT)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrBits     (busWrData[PW-1:0]),
    .tickMatch  (tickMatch),
    .stickMatch (stickMatch),
    .pendReg    (pendReg),
    .pilReg     (pilReg)
  );

  softint_reqgen #(.PW(PW), .LW(LW), .THRESH(THRESH)) req_i (
    .pendReg (pendReg),
    .pilReg  (pilReg),
    .intReq  (intReq)
  );

  always_comb begin
    if (regAddr_e'(busAddr) == ADDR_LEVEL) busRdData = DW'(pilReg);
    else                                   busRdData = DW'(pendReg);
  end

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intReq & ~pendReg) == '0);

  // R7
  timer_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pilReg >= LW'(THRESH)) |-> (!intReq[0] && !intReq[PW-1]));

  // R6
  top_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pilReg == LW'(PW-2)) |-> !intReq[PW-2]);

endmodule

// File: tb/softint_pend_tb_top.sv
module softint_pend_tb_top;

  localparam int NV = 15;
  localparam int ROW_W = 58;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;
  logic        tickMatch = 1'b0;
  logic        stickMatch = 1'b0;
  logic [16:0] intReq;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;

  softint_pend dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .tickMatch  (tickMatch),
    .stickMatch (stickMatch),
    .intReq     (intReq)
  );

  // row: {wrEn, addr[1:0], data[31:0], tick, stick, expPend[16:0], expPil[3:0]}
  localparam logic [ROW_W-1:0] VEC [NV] = '{
    {1'b1, 2'd3, 32'h0000_0000, 1'b0, 1'b0, 17'h00000, 4'd0},
    {1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 17'h1FFFF, 4'd0},
    {1'b1, 2'd2, 32'h0000_F0F0, 1'b0, 1'b0, 17'h10F0F, 4'd0},
    {1'b1, 2'd3, 32'h0000_0007, 1'b0, 1'b0, 17'h10F0F, 4'd7},
    {1'b1, 2'd1, 32'h0000_00F0, 1'b0, 1'b0, 17'h10FFF, 4'd7},
    {1'b1, 2'd3, 32'h0000_000D, 1'b0, 1'b0, 17'h10FFF, 4'd13},
    {1'b1, 2'd1, 32'h0000_C000, 1'b0, 1'b0, 17'h1CFFF, 4'd13},
    {1'b1, 2'd3, 32'hFFFF_FFFE, 1'b0, 1'b0, 17'h1CFFF, 4'd14},
    {1'b1, 2'd3, 32'h0000_000F, 1'b0, 1'b0, 17'h1CFFF, 4'd15},
    {1'b1, 2'd0, 32'h0000_0000, 1'b1, 1'b0, 17'h00001, 4'd15},
    {1'b1, 2'd2, 32'h0001_0001, 1'b1, 1'b1, 17'h10001, 4'd15},
    {1'b0, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 17'h10001, 4'd15},
    {1'b1, 2'd0, 32'hFFFE_0000, 1'b0, 1'b0, 17'h00000, 4'd15},
    {1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 17'h10000, 4'd15},
    {1'b1, 2'd3, 32'h0000_0000, 1'b0, 1'b0, 17'h10000, 4'd0}
  };

  localparam string ROW_REQ [NV] = '{
    "R5", "R2", "R4", "R6", "R3", "R7", "R6", "R7",
    "R7", "R9", "R9", "R4", "R2", "R8", "R10"
  };

  function automatic logic [16:0] reqModel(input logic [16:0] pend, input logic [3:0] pil);
    logic [16:0] r;
    r = '0;
    for (int k = 1; k <= 15; k++) r[k] = pend[k] && (k > int'(pil));
    r[0]  = pend[0]  && (pil < 4'd14);
    r[16] = pend[16] && (pil < 4'd14);
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req, input logic [16:0] expPend,
                            input logic [3:0] expPil);
    busWrEn = 1'b0;
    busAddr = 2'd0;
    #1;
    check(req, "pending read", busRdData, {15'd0, expPend});
    busAddr = 2'd1;
    #1;
    check(req, "pending read via set alias", busRdData, {15'd0, expPend});
    busAddr = 2'd3;
    #1;
    check(req, "level read", busRdData, {28'd0, expPil});
    check(req, "requests", {15'd0, intReq}, {15'd0, reqModel(expPend, expPil)});
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [ROW_W-1:0] row;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checkState("R1", 17'h00000, 4'd15);
    check("R1", "requests low", {15'd0, intReq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      row = VEC[i];
      busWrEn    = row[57];
      busAddr    = row[56:55];
      busWrData  = row[54:23];
      tickMatch  = row[22];
      stickMatch = row[21];
      @(negedge clk);
      tickMatch  = 1'b0;
      stickMatch = 1'b0;
      checkState(ROW_REQ[i], row[20:4], row[3:0]);
    end

    // R10: request appears right after the edge that stores a set-alias write
    busWrEn = 1'b1; busAddr = 2'd1; busWrData = 32'h0000_0020;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R10", "request bit 5 one cycle after write", {31'd0, intReq[5]}, 32'd1);

    // R2: clear-alias read also returns the pending register
    busAddr = 2'd2;
    #1;
    check("R2", "pending read via clear alias", busRdData, 32'h0001_0020);

    // R9: direct write of zero beside a system-tick pulse
    busWrEn = 1'b1; busAddr = 2'd0; busWrData = 32'h0000_0000; stickMatch = 1'b1;
    @(negedge clk);
    stickMatch = 1'b0;
    checkState("R9", 17'h10000, 4'd0);

    // R1: reset mid-run returns every state to its reset value
    rstN = 1'b0;
    busWrEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkState("R1", 17'h00000, 4'd15);

    finish();
  end

endmodule